// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller with Priority Chain

This block raises interrupts for a display peripheral that has two internal event sources: a smooth-scroll event (source 0, higher priority) and a vertical-position event (source 1, lower priority). Each source has three bits: pending, enable and in-service. A CPU reads and writes these bits through one control word. The block also takes part in a daisy-chain that sets priority across several devices. It has a chain input (`iei`) and a chain output (`ieo`), and it drives an active-low request line.

The vertical event is detected inside the block. It is flagged when a row counter moves onto the programmed interrupt row. When the CPU acknowledges while the block is requesting, the block marks the winning source as in service. On the following cycle it presents a programmed vector for one cycle, unless vector output has been inhibited. A single control bit lets software cut the chain so that every device further down is blocked.

Top module: `icu_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every control bit is 0, `int_n` is 1, `vec_valid` is 0 and `vec_out` is 0.
- R2: The vertical pending bit (bit 1) is set on the clock edge where `row_cnt` first equals `vint_row`. It is set only once for each arrival at that row. `src_evt[0]` sets the scroll pending bit (bit 0). A hardware set wins over a write that clears the same bit in the same cycle.
- R3: A write with `cfg_we` loads the whole control word, which reads back on `stat_out`. The word has the layout: bit0 scroll pending, bit1 vertical pending, bit2 scroll enable, bit3 vertical enable, bit4 scroll in service, bit5 vertical in service, bit6 vector inhibit, bit7 chain cut. `int_n` follows the control state one clock later, so clearing a pending bit releases the request on the next clock.
- R4: `int_n` is driven low only when three conditions hold: `iei` is high, some source is both pending and enabled, and no source of equal or higher priority is in service.
- R5: Scroll has priority over vertical. A vertical in-service bit does not block a scroll request. A scroll in-service bit blocks both sources.
- R6: `iack` is accepted only while the block is requesting in that cycle and no write is taking place. An accepted acknowledge sets the in-service bit of the highest-priority requesting source and leaves the pending bits unchanged. On the next cycle, `vec_valid` is high for one cycle with `vec_out` equal to `vec_base`.
- R7: In-service bits are never cleared by the hardware. Only a CPU write clears them.
- R8: `ieo` is the registered value of `iei` AND no in-service bit set AND chain cut clear. This holds even when the in-service source is disabled.
- R9: While vector inhibit is 1, an accepted acknowledge still sets the in-service bit, but `vec_valid` stays 0 and `vec_out` stays 0.
- R10: A pending bit whose enable bit is 0 never causes `int_n` to go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_cnt | input | ROW_W | Current row count from the display timing |
| vint_row | input | ROW_W | Programmed row that raises the vertical event |
| src_evt | input | N_SRC-1 | Event pulses for the non-vertical sources (bit 0 = scroll) |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | CTL_W | Control word write data |
| stat_out | output | CTL_W | Control word read-back |
| vec_base | input | VEC_W | Programmed interrupt vector |
| iack | input | 1 | Interrupt acknowledge cycle |
| iei | input | 1 | Chain input; high means higher-priority devices allow this one |
| int_n | output | 1 | Active-low interrupt request |
| ieo | output | 1 | Chain output to lower-priority devices |
| vec_out | output | VEC_W | Vector driven after an accepted acknowledge |
| vec_valid | output | 1 | High for one cycle when `vec_out` carries a vector |

## Verification
The hardest situation to reach is one where the in-service state and the enables disagree. Two examples are a disabled source whose in-service bit must still block the chain, and a scroll request that must get through while the vertical source is in service. These states take a full request and acknowledge sequence to reach naturally. The stimulus instead writes the control word directly to set the in-service bits, then watches `int_n` and `ieo` two clocks later. Acknowledges are also sent with `iei` low, and while nothing is enabled, to show that the in-service bits and the vector stay untouched.

// File: rtl/icu_pkg.sv
package icu_pkg;
  // Control word field positions as a function of the source count.
  function automatic int pend_lo(input int n);  return 0;        endfunction
  function automatic int en_lo(input int n);    return n;        endfunction
  function automatic int ius_lo(input int n);   return 2 * n;    endfunction
  function automatic int nv_pos(input int n);   return 3 * n;    endfunction
  function automatic int cut_pos(input int n);  return 3 * n + 1; endfunction
  function automatic int ctl_width(input int n); return 3 * n + 2; endfunction
endpackage

// File: rtl/icu_rowhit.sv
module icu_rowhit #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] row_cnt,
  input  logic [ROW_W-1:0] vint_row,
  output logic             hit
);
  logic eq, eq_q;

  assign eq  = (row_cnt == vint_row);
  assign hit = eq & ~eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end
endmodule

// File: rtl/icu_arb.sv
module icu_arb #(
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] ius,
  input  logic             iei,
  output logic             req,
  output logic [N_SRC-1:0] grant
);
  logic [N_SRC-1:0] blocked, cand;

  // Index 0 is the highest priority; an in-service bit blocks itself and below.
  for (genvar i = 0; i < N_SRC; i++) begin : g_blk
    assign blocked[i] = |ius[i:0];
  end

  assign cand  = pend & en & ~blocked;
  assign req   = iei & (|cand);
  assign grant = cand & (~cand + 1'b1);
endmodule

// File: rtl/icu_ctlreg.sv
module icu_ctlreg #(
  parameter int N_SRC = 2,
  localparam int CTL_W = 3 * N_SRC + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic [N_SRC-1:0] hw_set,
  input  logic             ack_take,
  input  logic [N_SRC-1:0] grant,
  output logic [CTL_W-1:0] ctl
);
  localparam int PH = N_SRC - 1;
  localparam int IL = 2 * N_SRC;
  localparam int IH = 3 * N_SRC - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (we) begin
      ctl        <= wdata;
      ctl[PH:0]  <= wdata[PH:0] | hw_set;
    end else begin
      ctl[PH:0] <= ctl[PH:0] | hw_set;
      if (ack_take) ctl[IH:IL] <= ctl[IH:IL] | grant;
    end
  end
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int N_SRC = 2,
  parameter int ROW_W = 10,
  parameter int VEC_W = 8,
  localparam int CTL_W = 3 * N_SRC + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] row_cnt,
  input  logic [ROW_W-1:0] vint_row,
  input  logic [N_SRC-2:0] src_evt,
  input  logic             cfg_we,
  input  logic [CTL_W-1:0] cfg_wdata,
  output logic [CTL_W-1:0] stat_out,
  input  logic [VEC_W-1:0] vec_base,
  input  logic             iack,
  input  logic             iei,
  output logic             int_n,
  output logic             ieo,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  localparam int EL  = en_lo(N_SRC);
  localparam int IL  = ius_lo(N_SRC);
  localparam int NV  = nv_pos(N_SRC);
  localparam int CUT = cut_pos(N_SRC);

  logic [CTL_W-1:0] ctl_q;
  logic [N_SRC-1:0] pend, en, ius, grant, hw_set;
  logic             row_hit, req, ack_take;

  assign pend = ctl_q[EL-1:0];
  assign en   = ctl_q[IL-1:EL];
  assign ius  = ctl_q[NV-1:IL];

  icu_rowhit #(.ROW_W(ROW_W)) u_rowhit (
    .clk(clk), .rst(rst), .row_cnt(row_cnt), .vint_row(vint_row), .hit(row_hit)
  );

  assign hw_set = {row_hit, src_evt};

  icu_arb #(.N_SRC(N_SRC)) u_arb (
    .pend(pend), .en(en), .ius(ius), .iei(iei), .req(req), .grant(grant)
  );

  assign ack_take = iack & req & ~cfg_we;

  icu_ctlreg #(.N_SRC(N_SRC)) u_ctl (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .hw_set(hw_set),
    .ack_take(ack_take), .grant(grant), .ctl(ctl_q)
  );

  assign stat_out = ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n     <= 1'b1;
      ieo       <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      int_n     <= ~req;
      ieo       <= iei & ~(|ius) & ~ctl_q[CUT];
      vec_valid <= ack_take & ~ctl_q[NV];
      vec_out   <= (ack_take & ~ctl_q[NV]) ? vec_base : '0;
    end
  end
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
  parameter int N_SRC = 2,
  localparam int CTL_W = 3 * N_SRC + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             iei,
  input logic             cfg_we,
  input logic             int_n,
  input logic             ieo,
  input logic             vec_valid,
  input logic [CTL_W-1:0] ctl
);
  localparam int EL = N_SRC;
  localparam int IL = 2 * N_SRC;
  localparam int IH = 3 * N_SRC - 1;
  localparam int NV = 3 * N_SRC;
  localparam int CUT = 3 * N_SRC + 1;

  logic [N_SRC-1:0] ius_v, live;
  assign ius_v = ctl[IH:IL];
  assign live  = ctl[EL-1:0] & ctl[IL-1:EL];

  AST_NO_REQ_WITHOUT_IEI: assert property (@(posedge clk) disable iff (rst)
    !iei |=> int_n); // R4
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !(|live) |=> int_n); // R10
  AST_IUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ((ius_v & $past(ius_v)) == $past(ius_v))); // R7
  AST_IUS_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (|ius_v) |=> !ieo); // R8
  AST_CUT_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    ctl[CUT] |=> !ieo); // R8
  AST_NOVEC_SILENT: assert property (@(posedge clk) disable iff (rst)
    ctl[NV] |=> !vec_valid); // R9
  AST_VEC_NEEDS_IEI: assert property (@(posedge clk) disable iff (rst)
    !iei |=> !vec_valid); // R6
endmodule

bind icu_top icu_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .iei(iei), .cfg_we(cfg_we), .int_n(int_n),
  .ieo(ieo), .vec_valid(vec_valid), .ctl(ctl_q)
);

// File: tb/tb_icu_top.sv
module tb_icu_top;
  localparam int N_SRC = 2;
  localparam int ROW_W = 10;
  localparam int VEC_W = 8;
  localparam int CTL_W = 3 * N_SRC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ROW_W-1:0] row_cnt = '0, vint_row = 10'd5;
  logic [N_SRC-2:0] src_evt = '0;
  logic cfg_we = 1'b0;
  logic [CTL_W-1:0] cfg_wdata = '0, stat_out;
  logic [VEC_W-1:0] vec_base = 8'hA5, vec_out;
  logic iack = 1'b0, iei = 1'b1;
  logic int_n, ieo, vec_valid;

  always #4 clk = ~clk;

  icu_top #(.N_SRC(N_SRC), .ROW_W(ROW_W), .VEC_W(VEC_W)) dut (
    .clk(clk), .rst(rst), .row_cnt(row_cnt), .vint_row(vint_row),
    .src_evt(src_evt), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stat_out(stat_out), .vec_base(vec_base), .iack(iack), .iei(iei),
    .int_n(int_n), .ieo(ieo), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  typedef struct {
    string            tag;
    logic             e_int;
    logic             e_ieo;
    logic             e_vv;
    logic [VEC_W-1:0] e_vec;
    logic [CTL_W-1:0] e_stat;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [CTL_W-1:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic ei, input logic eo,
                            input logic vv, input logic [CTL_W-1:0] st);
    exp_t e;
    e.tag = tag; e.e_int = ei; e.e_ieo = eo; e.e_vv = vv;
    e.e_vec = vv ? vec_base : '0; e.e_stat = st;
    sb.push_back(e);
  endtask

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (int_n !== e.e_int || ieo !== e.e_ieo || vec_valid !== e.e_vv ||
          vec_out !== e.e_vec || stat_out !== e.e_stat) begin
        errors++;
        $display("FAIL %s: int_n=%b ieo=%b vv=%b vec=%h stat=%h expected int_n=%b ieo=%b vv=%b vec=%h stat=%h",
                 e.tag, int_n, ieo, vec_valid, vec_out, stat_out,
                 e.e_int, e.e_ieo, e.e_vv, e.e_vec, e.e_stat);
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    expect_out("R1 in reset", 1, 0, 0, 8'h00);
    rst = 1'b0;
    tick();
    expect_out("R1 after reset", 1, 1, 0, 8'h00);

    // R2 row arrival, R10 disabled source stays silent
    row_cnt = 10'd5;
    tick(); tick();
    expect_out("R2 R10 row hit disabled", 1, 1, 0, 8'h02);
    wr(8'h00); tick();
    expect_out("R2 once per arrival", 1, 1, 0, 8'h00);
    row_cnt = 10'd6;

    // R4 enabled pending requests
    wr(8'h0A); tick();
    expect_out("R4 request asserted", 0, 1, 0, 8'h0A);
    // R3 clear releases request one clock later
    wr(8'h08);
    expect_out("R3 clear same clock", 0, 1, 0, 8'h08);
    tick();
    expect_out("R3 released next clock", 1, 1, 0, 8'h08);

    // R5/R6 both pending, scroll wins
    wr(8'h0F); tick();
    expect_out("R4 both pending", 0, 1, 0, 8'h0F);
    iack = 1'b1; tick(); iack = 1'b0;
    expect_out("R6 R5 ack scroll", 0, 1, 1, 8'h1F);
    tick();
    expect_out("R5 R8 scroll in service blocks", 1, 0, 0, 8'h1F);
    tick(); tick();
    expect_out("R7 in-service sticky", 1, 0, 0, 8'h1F);
    wr(8'h0F);
    expect_out("R7 cleared by write", 1, 0, 0, 8'h0F);
    tick();
    expect_out("R7 request returns", 0, 1, 0, 8'h0F);

    // R6 vertical alone
    wr(8'h0E); tick();
    expect_out("R4 vertical request", 0, 1, 0, 8'h0E);
    iack = 1'b1; tick(); iack = 1'b0;
    expect_out("R6 ack vertical", 0, 1, 1, 8'h2E);
    tick();
    expect_out("R8 vertical in service", 1, 0, 0, 8'h2E);
    wr(8'h2D); tick();
    expect_out("R5 scroll passes lower in-service", 0, 0, 0, 8'h2D);
    wr(8'h20); tick();
    expect_out("R8 disabled source still blocks", 1, 0, 0, 8'h20);

    // R4/R6 chain input low
    iei = 1'b0; wr(8'h05); tick();
    expect_out("R4 iei low no request", 1, 0, 0, 8'h05);
    iack = 1'b1; tick(); iack = 1'b0;
    expect_out("R6 ack ignored iei low", 1, 0, 0, 8'h05);
    iei = 1'b1; tick(); tick();
    expect_out("R4 iei high request", 0, 1, 0, 8'h05);

    // R9 vector inhibit
    wr(8'h45); tick();
    expect_out("R9 setup", 0, 1, 0, 8'h45);
    iack = 1'b1; tick(); iack = 1'b0;
    expect_out("R9 no vector but in service", 0, 1, 0, 8'h55);
    tick();
    expect_out("R9 blocked after ack", 1, 0, 0, 8'h55);

    // R8 chain cut
    wr(8'h80); tick();
    expect_out("R8 chain cut", 1, 0, 0, 8'h80);
    wr(8'h00); tick();
    expect_out("R8 chain restored", 1, 1, 0, 8'h00);

    // R2 scroll event, event wins over clearing write
    src_evt = 1'b1; tick(); src_evt = 1'b0;
    expect_out("R2 scroll event", 1, 1, 0, 8'h01);
    src_evt = 1'b1; wr(8'h00); src_evt = 1'b0;
    expect_out("R2 event beats write", 1, 1, 0, 8'h01);
    iack = 1'b1; tick(); iack = 1'b0;
    expect_out("R6 ack without request", 1, 1, 0, 8'h01);

    @(negedge clk); #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule